// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit CPU core and decides, at each instruction boundary, which one is serviced next. Peripheral requests arrive as parallel vectors of status flags and enable bits. Several flag/enable pairs may share one interrupt line. Three further requests are one-shot pulses raised by the core: software trap, illegal opcode and the non-maskable pin. The controller keeps all of these in a registered pending vector.

The selection is combinational. It reads the pending vector and the core's two condition-code mask bits, I and X. It presents a valid flag, a 5-bit interrupt number and the vector fetch address. When the core commits with the single-cycle take strobe, the controller does three things: it pulses the mask bit the core must set, it reports the fixed entry overhead, and it retires the request if that request is one-shot. Peripheral register decoding, stacking and vector memory reads belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source k (k >= 4) drives line k+8 alone. Its pending bit is set one cycle after flag and enable are both 1, and it is cleared one cycle after either one is 0.
- R2: Sources 0..3 share line 11. Clears are applied before sets, so the line stays pending while any of the four pairs is active, and it drops one cycle after none is.
- R3: Software trap (line 27) wins over illegal opcode (line 28), and both win over everything else. Neither is affected by I or X. A taken one-shot request is cleared at the next edge.
- R4: A pending non-maskable request (line 26) is selected when X=0 and cleared when taken. When X=1 nothing is selected, even if lower sources are pending.
- R5: With I=1, no peripheral line is selected.
- R6: Peripheral lines are scanned through a 32-slot order table. At reset each slot holds its own index. A write of ord_id_i into slot ord_slot_i takes effect from the next cycle. The lowest slot whose line is pending wins.
- R7: Taking a peripheral line does not clear its pending bit.
- R8: vec_addr_o equals the base plus twice the selected number. The base is 0xFFC0, or 0xBFC0 when boot_mode_i=1.
- R9: During a take of a valid selection, set_xmask_o pulses for line 26 and set_imask_o pulses for any other line. Outside a take, neither pulses.
- R10: take_cost_o is 14 during a take of a valid selection and 0 otherwise.
- R11: Reset empties the pending vector, so no selection is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 17 | Peripheral status flags |
| en_i | input | 17 | Peripheral enable bits |
| swi_req_i | input | 1 | Software trap request pulse |
| ill_req_i | input | 1 | Illegal opcode request pulse |
| xirq_req_i | input | 1 | Non-maskable pin request pulse |
| mask_i_i | input | 1 | Condition-code I bit |
| mask_x_i | input | 1 | Condition-code X bit |
| boot_mode_i | input | 1 | Selects the bootstrap vector base |
| ord_we_i | input | 1 | Order table write strobe |
| ord_slot_i | input | 5 | Order table slot to write |
| ord_id_i | input | 5 | Line number stored in the slot |
| take_i | input | 1 | Core commits the current selection |
| sel_valid_o | output | 1 | A request is selectable |
| sel_id_o | output | 5 | Selected interrupt number |
| vec_addr_o | output | 16 | Vector fetch address |
| set_imask_o | output | 1 | Pulse: core sets I |
| set_xmask_o | output | 1 | Pulse: core sets X |
| take_cost_o | output | 4 | Entry overhead in cycles on a take |
| pend_o | output | 32 | Pending vector |

## Verification
The hardest case to reach is a non-maskable request held off by X while a peripheral line is also pending. To get there, the stimulus raises the pin pulse with X=1 and a live peripheral pair, and checks that nothing is selected. It then clears X, takes the request, and confirms that the peripheral line comes back. The shared line is driven through overlapping pairs that drop one at a time. Both one-shot requests are raised in the same cycle under full masking, so the trap-then-illegal order shows on two consecutive takes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ID_W      = 5;
  localparam int NUM_LINES = 1 << ID_W;
  localparam int ADDR_W    = 16;
  localparam int SHARED_N  = 4;
  localparam int SHARED_ID = 11;

  // flag/enable pair k -> interrupt line
  function automatic logic [ID_W-1:0] src_line(input int k);
    return (k < SHARED_N) ? ID_W'(SHARED_ID) : ID_W'(k + 8);
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 17,
  parameter int SWI_ID  = 27,
  parameter int ILL_ID  = 28,
  parameter int XIRQ_ID = 26
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   flag_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic                 swi_req_i,
  input  logic                 ill_req_i,
  input  logic                 xirq_req_i,
  input  logic                 take_i,
  input  logic                 sel_valid_i,
  input  logic [ID_W-1:0]      sel_id_i,
  output logic [NUM_LINES-1:0] pend_o
);
  localparam logic [NUM_LINES-1:0] ONESHOT =
    (NUM_LINES'(1) << SWI_ID) | (NUM_LINES'(1) << ILL_ID) | (NUM_LINES'(1) << XIRQ_ID);

  logic [NUM_LINES-1:0] pend_q, pend_d, clr_m, set_m;

  always_comb begin
    clr_m = '0;
    set_m = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (flag_i[k] && en_i[k]) set_m[src_line(k)] = 1'b1;
      else                      clr_m[src_line(k)] = 1'b1;
    end
  end

  always_comb begin
    pend_d = (pend_q & ~clr_m) | set_m;
    if (take_i && sel_valid_i && ONESHOT[sel_id_i]) pend_d[sel_id_i] = 1'b0;
    if (swi_req_i)  pend_d[SWI_ID]  = 1'b1;
    if (ill_req_i)  pend_d[ILL_ID]  = 1'b1;
    if (xirq_req_i) pend_d[XIRQ_ID] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar k = SHARED_N; k < NUM_SRC; k++) begin : g_single_chk
    localparam int LN = int'(src_line(k));
    assert_single_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[k] && en_i[k]) |=> pend_q[LN]);
    assert_single_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(flag_i[k] && en_i[k]) |=> !pend_q[LN]);
  end

  if (NUM_SRC >= SHARED_N) begin : g_shared_chk
    logic [SHARED_N-1:0] grp_act;
    assign grp_act = flag_i[SHARED_N-1:0] & en_i[SHARED_N-1:0];
    assert_shared_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|grp_act) |=> pend_q[SHARED_ID]);
    assert_shared_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|grp_act) |=> !pend_q[SHARED_ID]);
  end

  assert_swi_retire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && sel_valid_i && sel_id_i == ID_W'(SWI_ID) && !swi_req_i) |=> !pend_q[SWI_ID]);
endmodule

// File: rtl/irq_order_tbl.sv
module irq_order_tbl
  import irq_ctrl_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ID_W-1:0]                 slot_i,
  input  logic [ID_W-1:0]                 id_i,
  output logic [NUM_LINES-1:0][ID_W-1:0]  order_o
);
  logic [NUM_LINES-1:0][ID_W-1:0] ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) ord_q[i] <= ID_W'(i);
    end else if (we_i) begin
      ord_q[slot_i] <= id_i;
    end
  end

  assign order_o = ord_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_ctrl_pkg::*;
#(
  parameter int SWI_ID  = 27,
  parameter int ILL_ID  = 28,
  parameter int XIRQ_ID = 26
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_LINES-1:0]            pend_i,
  input  logic [NUM_LINES-1:0][ID_W-1:0]  order_i,
  input  logic                            mask_i_i,
  input  logic                            mask_x_i,
  output logic                            valid_o,
  output logic [ID_W-1:0]                 id_o
);
  logic            scan_hit;
  logic [ID_W-1:0] scan_id;

  // descending loop: lowest slot with a pending line wins
  always_comb begin
    scan_hit = 1'b0;
    scan_id  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_i[order_i[i]]) begin
        scan_hit = 1'b1;
        scan_id  = order_i[i];
      end
    end
  end

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    if (pend_i[SWI_ID]) begin
      valid_o = 1'b1;
      id_o    = ID_W'(SWI_ID);
    end else if (pend_i[ILL_ID]) begin
      valid_o = 1'b1;
      id_o    = ID_W'(ILL_ID);
    end else if (pend_i[XIRQ_ID]) begin
      valid_o = !mask_x_i;
      id_o    = ID_W'(XIRQ_ID);
    end else if (!mask_i_i) begin
      valid_o = scan_hit;
      id_o    = scan_id;
    end
  end

  assert_xmask_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[XIRQ_ID] && !pend_i[SWI_ID] && !pend_i[ILL_ID] && mask_x_i) |-> !valid_o);
  assert_imask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i_i && !pend_i[XIRQ_ID] && !pend_i[SWI_ID] && !pend_i[ILL_ID]) |-> !valid_o);
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_ctrl_pkg::*;
#(
  parameter int              XIRQ_ID   = 26,
  parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
  parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0,
  parameter int              TAKE_COST = 14,
  localparam int             COST_W    = $clog2(TAKE_COST + 1)
) (
  input  logic              boot_mode_i,
  input  logic              take_i,
  input  logic              sel_valid_i,
  input  logic [ID_W-1:0]   sel_id_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              set_imask_o,
  output logic              set_xmask_o,
  output logic [COST_W-1:0] cost_o
);
  logic commit;
  logic is_nmi;

  assign commit     = take_i && sel_valid_i;
  assign is_nmi     = (sel_id_i == ID_W'(XIRQ_ID));
  assign vec_addr_o = (boot_mode_i ? BASE_BOOT : BASE_NORM) + ADDR_W'({sel_id_i, 1'b0});
  assign set_xmask_o = commit && is_nmi;
  assign set_imask_o = commit && !is_nmi;
  assign cost_o      = commit ? COST_W'(TAKE_COST) : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC   = 17,
  parameter int SWI_ID    = 27,
  parameter int ILL_ID    = 28,
  parameter int XIRQ_ID   = 26,
  parameter int TAKE_COST = 14,
  localparam int COST_W   = $clog2(TAKE_COST + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   flag_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic                 swi_req_i,
  input  logic                 ill_req_i,
  input  logic                 xirq_req_i,
  input  logic                 mask_i_i,
  input  logic                 mask_x_i,
  input  logic                 boot_mode_i,
  input  logic                 ord_we_i,
  input  logic [ID_W-1:0]      ord_slot_i,
  input  logic [ID_W-1:0]      ord_id_i,
  input  logic                 take_i,
  output logic                 sel_valid_o,
  output logic [ID_W-1:0]      sel_id_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic                 set_imask_o,
  output logic                 set_xmask_o,
  output logic [COST_W-1:0]    take_cost_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0]           pend;
  logic [NUM_LINES-1:0][ID_W-1:0] order;
  logic                           sel_valid;
  logic [ID_W-1:0]                sel_id;

  irq_pending #(
    .NUM_SRC(NUM_SRC), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) i_pending (
    .clk_i, .rst_ni, .flag_i, .en_i, .swi_req_i, .ill_req_i, .xirq_req_i, .take_i,
    .sel_valid_i(sel_valid), .sel_id_i(sel_id), .pend_o(pend)
  );

  irq_order_tbl i_order (
    .clk_i, .rst_ni, .we_i(ord_we_i), .slot_i(ord_slot_i), .id_i(ord_id_i), .order_o(order)
  );

  irq_select #(
    .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) i_select (
    .clk_i, .rst_ni, .pend_i(pend), .order_i(order), .mask_i_i, .mask_x_i,
    .valid_o(sel_valid), .id_o(sel_id)
  );

  irq_vector #(
    .XIRQ_ID(XIRQ_ID), .TAKE_COST(TAKE_COST)
  ) i_vector (
    .boot_mode_i, .take_i, .sel_valid_i(sel_valid), .sel_id_i(sel_id),
    .vec_addr_o, .set_imask_o, .set_xmask_o, .cost_o(take_cost_o)
  );

  assign sel_valid_o = sel_valid;
  assign sel_id_o    = sel_id;
  assign pend_o      = pend;

  assert_nmi_take_retires_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_xmask_o && !xirq_req_i) |=> !pend_o[XIRQ_ID]);
  assert_cost_on_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_cost_o != '0) |-> (set_imask_o ^ set_xmask_o));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NS = 17;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [NS-1:0] flag_i = '0, en_i = '0;
  logic        swi_req_i = 0, ill_req_i = 0, xirq_req_i = 0;
  logic        mask_i_i = 0, mask_x_i = 0, boot_mode_i = 0;
  logic        ord_we_i = 0, take_i = 0;
  logic [4:0]  ord_slot_i = '0, ord_id_i = '0;
  logic        sel_valid_o, set_imask_o, set_xmask_o;
  logic [4:0]  sel_id_o;
  logic [15:0] vec_addr_o;
  logic [3:0]  take_cost_o;
  logic [31:0] pend_o;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;

  typedef struct {
    bit          kind;
    logic        v;
    logic [4:0]  id;
    logic        si, sx;
    logic [3:0]  cost;
    logic [31:0] pm, pv;
  } item_t;
  item_t q[$];
  string tq[$];

  task automatic exp_sel(string t, logic v, logic [4:0] id, logic si, logic sx, logic [3:0] c);
    item_t it;
    it.kind = 0; it.v = v; it.id = id; it.si = si; it.sx = sx; it.cost = c;
    it.pm = '0; it.pv = '0;
    q.push_back(it); tq.push_back(t);
  endtask

  task automatic exp_pend(string t, logic [31:0] pm, logic [31:0] pv);
    item_t it;
    it.kind = 1; it.v = 0; it.id = '0; it.si = 0; it.sx = 0; it.cost = '0;
    it.pm = pm; it.pv = pv;
    q.push_back(it); tq.push_back(t);
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // monitor: checks items queued at the last falling edge, 1 ns before the rising edge
  initial forever begin
    item_t it;
    string t;
    logic [15:0] ea;
    @(negedge clk_i);
    #4;
    while (q.size() > 0) begin
      it = q.pop_front();
      t  = tq.pop_front();
      n_vec++;
      if (it.kind == 0) begin
        ea = (boot_mode_i ? 16'hBFC0 : 16'hFFC0) + {10'd0, it.id, 1'b0};
        if (sel_valid_o !== it.v || (it.v && (sel_id_o !== it.id || vec_addr_o !== ea)) ||
            set_imask_o !== it.si || set_xmask_o !== it.sx || take_cost_o !== it.cost) begin
          n_bad++;
          $display("FAIL %s: got v=%b id=%0d addr=%h si=%b sx=%b cost=%0d, want v=%b id=%0d addr=%h si=%b sx=%b cost=%0d",
                   t, sel_valid_o, sel_id_o, vec_addr_o, set_imask_o, set_xmask_o, take_cost_o,
                   it.v, it.id, ea, it.si, it.sx, it.cost);
        end
      end else if ((pend_o & it.pm) !== it.pv) begin
        n_bad++;
        $display("FAIL %s: pending got %h want %h (mask %h)", t, pend_o & it.pm, it.pv, it.pm);
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog (R1..R11 run): got hung want finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    exp_pend("R11 reset empty", 32'hFFFF_FFFF, 32'h0);
    exp_sel("R11 no select", 0, 0, 0, 0, 0);

    tick(); flag_i[5] = 1;                 // line 13, enable off
    exp_sel("R1 flag only", 0, 0, 0, 0, 0);
    tick();
    exp_pend("R1 flag without enable", 32'h1 << 13, 32'h0);
    tick(); en_i[5] = 1;
    exp_sel("R1 enable not yet seen", 0, 0, 0, 0, 0);
    tick();
    exp_sel("R1 R8 line 13", 1, 13, 0, 0, 0);
    exp_pend("R1 set", 32'h1 << 13, 32'h1 << 13);

    tick(); flag_i[16] = 1; en_i[16] = 1; // line 24
    exp_sel("R6 identity keeps 13", 1, 13, 0, 0, 0);
    tick();
    exp_sel("R6 lower slot wins", 1, 13, 0, 0, 0);
    exp_pend("R1 line 24 set", 32'h1 << 24, 32'h1 << 24);
    tick(); ord_we_i = 1; ord_slot_i = 0; ord_id_i = 24;
    exp_sel("R6 write not yet active", 1, 13, 0, 0, 0);
    tick(); ord_we_i = 0;
    exp_sel("R6 reordered to 24", 1, 24, 0, 0, 0);
    tick(); mask_i_i = 1;
    exp_sel("R5 I masks", 0, 0, 0, 0, 0);
    tick(); mask_i_i = 0; take_i = 1;
    exp_sel("R9 R10 take maskable", 1, 24, 1, 0, 14);
    tick(); take_i = 0;
    exp_sel("R7 R9 R10 still selected", 1, 24, 0, 0, 0);
    exp_pend("R7 pending kept", 32'h1 << 24, 32'h1 << 24);
    tick(); boot_mode_i = 1;
    exp_sel("R8 boot base", 1, 24, 0, 0, 0);
    tick(); boot_mode_i = 0; flag_i = '0; en_i = '0;
    exp_sel("R1 drop not yet seen", 1, 24, 0, 0, 0);
    tick();
    exp_sel("R1 cleared", 0, 0, 0, 0, 0);
    exp_pend("R1 all clear", 32'hFFFF_FFFF, 32'h0);

    tick(); flag_i[0] = 1; en_i[0] = 1; flag_i[2] = 1; en_i[2] = 1;
    exp_sel("R2 shared idle", 0, 0, 0, 0, 0);
    tick(); flag_i[0] = 0;
    exp_sel("R2 shared line", 1, 11, 0, 0, 0);
    tick();
    exp_sel("R2 one pair holds", 1, 11, 0, 0, 0);
    exp_pend("R2 held", 32'h1 << 11, 32'h1 << 11);
    tick(); flag_i[2] = 0;
    exp_sel("R2 last pair drops", 1, 11, 0, 0, 0);
    tick();
    exp_pend("R2 shared cleared", 32'h1 << 11, 32'h0);
    exp_sel("R2 none", 0, 0, 0, 0, 0);

    tick(); flag_i[4] = 1; en_i[4] = 1; mask_x_i = 1; xirq_req_i = 1;
    exp_sel("R4 idle", 0, 0, 0, 0, 0);
    tick(); xirq_req_i = 0;
    exp_sel("R4 X blocks lower", 0, 0, 0, 0, 0);
    exp_pend("R4 both pending", (32'h1 << 26) | (32'h1 << 12), (32'h1 << 26) | (32'h1 << 12));
    tick(); mask_x_i = 0; take_i = 1;
    exp_sel("R4 R9 R10 take nmi", 1, 26, 0, 1, 14);
    tick(); take_i = 0;
    exp_sel("R4 falls to line 12", 1, 12, 0, 0, 0);
    exp_pend("R4 nmi retired", 32'h1 << 26, 32'h0);

    tick(); flag_i[4] = 0; en_i[4] = 0; mask_i_i = 1; mask_x_i = 1;
    swi_req_i = 1; ill_req_i = 1;
    exp_sel("R5 masked", 0, 0, 0, 0, 0);
    tick(); swi_req_i = 0; ill_req_i = 0;
    exp_sel("R3 trap first despite masks", 1, 27, 0, 0, 0);
    exp_pend("R3 both one-shots", (32'h1 << 27) | (32'h1 << 28), (32'h1 << 27) | (32'h1 << 28));
    tick(); take_i = 1;
    exp_sel("R3 R9 take trap", 1, 27, 1, 0, 14);
    tick(); take_i = 0;
    exp_sel("R3 illegal next", 1, 28, 0, 0, 0);
    exp_pend("R3 trap retired", 32'h1 << 27, 32'h0);
    tick(); take_i = 1;
    exp_sel("R3 take illegal", 1, 28, 1, 0, 14);
    tick(); take_i = 0;
    exp_sel("R3 R9 R10 idle", 0, 0, 0, 0, 0);
    exp_pend("R3 all retired", 32'hFFFF_FFFF, 32'h0);

    tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule